// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the fetch stage of a small 64-bit sequential processor. Each cycle it takes a 10-byte window of instruction memory that starts at its own program counter. From that window it pulls out the opcode and function nibbles, the two register specifiers and the 64-bit constant. It also reports whether the instruction carries a register byte and whether it carries a constant, and works out the address of the next sequential instruction. Instruction lengths are 1, 2, 9 or 10 bytes.

Besides the usual instruction set, the block decodes an immediate-add opcode. Its register byte has the "no register" code in the first nibble and the target register in the second, and an 8-byte constant follows. The block holds the program counter and a run status. While running, it steps to the next sequential address on each clock. It stops for good when it fetches a halt or an encoding it does not recognise.

Top module: `insn_fetch_decode`

## Requirements
- R1: The opcode output is bits 7..4 of window byte 0, and the function output is bits 3..0 of window byte 0.
- R2: When a register byte is present (byte 1), the first specifier is its bits 7..4 and the second is its bits 3..0. When no register byte is present, both specifiers read 0xF.
- R3: The constant is assembled little-endian from 8 bytes. It starts at byte 2 when a register byte is present and at byte 1 otherwise. It reads 0 when the instruction has no constant.
- R4: Opcode 0xC with function 0 (immediate add) is valid. It has a register byte and a constant, and the next PC is PC+10.
- R5: Opcode 0x6 (register-register ALU) with function 0..3 is valid. It has a register byte and no constant, and the next PC is PC+2.
- R6: Lengths of the other valid opcodes: 0x0, 0x1 and 0x9 take 1 byte; 0x2, 0xA and 0xB take 2; 0x3, 0x4 and 0x5 take 10; 0x7 and 0x8 take 9 (constant, no register byte).
- R7: Function limits: opcodes 0x2 and 0x7 accept functions 0..6, opcode 0x6 accepts 0..3, and every other opcode accepts only 0. Opcodes 0xD..0xF and any out-of-range function drive the valid flag low.
- R8: After reset the PC equals RESET_PC (0 by default) and the status is 0 (running).
- R9: While the status is running and the fetched instruction is valid and not a halt, the PC takes the next-PC value at each clock edge.
- R10: While running, an invalid fetch sets the status to 2 at the next edge. The PC then stays frozen and the status stays at 2.
- R11: While running, a valid halt (opcode 0x0) sets the status to 1 at the next edge, and the PC holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| window_i | input | 80 | Instruction bytes at pc_o; byte k at bits 8k+7..8k |
| pc_o | output | 64 | Current program counter |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register specifier |
| rb_o | output | 4 | Second register specifier |
| valc_o | output | 64 | Constant field |
| valp_o | output | 64 | Next sequential PC |
| need_regids_o | output | 1 | Instruction carries a register byte |
| need_valc_o | output | 1 | Instruction carries a constant |
| instr_valid_o | output | 1 | Encoding is recognised |
| stat_o | output | 2 | 0 running, 1 halted, 2 invalid instruction |

## Verification
The bench aims at the immediate-add encoding. A decoder that treated it like the ALU opcode would report PC+2 and a zero constant. One that read the constant from byte 1 would produce a value shifted by a byte. Jump-style instructions have a constant but no register byte, so they catch a decoder with a fixed constant offset. Function limits are tested one value past each bound: a wrong limit either accepts 0x64 or 0xC1 or rejects 0x63. Halt and invalid fetches are stepped twice so that a PC that keeps moving, or a status that falls back to running, shows up at the ports.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [3:0] {
    OP_HALT  = 4'h0, OP_NOP   = 4'h1, OP_RRMOV = 4'h2, OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4, OP_MRMOV = 4'h5, OP_ALU   = 4'h6, OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8, OP_RET   = 4'h9, OP_PUSH  = 4'hA, OP_POP   = 4'hB,
    OP_IADD  = 4'hC
  } opcode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_INV  = 2'd2
  } stat_e;

  localparam logic [3:0] REG_NONE    = 4'hF;
  localparam logic [3:0] ALU_FUN_MAX = 4'd3;
  localparam logic [3:0] CND_FUN_MAX = 4'd6;
endpackage

// File: rtl/fd_classify.sv
module fd_classify
  import fd_pkg::*;
(
  input  logic [3:0] icode_i,
  input  logic [3:0] ifun_i,
  output logic       valid_o,
  output logic       need_regids_o,
  output logic       need_valc_o,
  output logic       is_halt_o
);
  logic       known;
  logic [3:0] fun_max;

  always_comb begin
    known         = 1'b1;
    fun_max       = 4'd0;
    need_regids_o = 1'b0;
    need_valc_o   = 1'b0;
    case (icode_i)
      OP_HALT, OP_NOP, OP_RET: ;
      OP_RRMOV: begin need_regids_o = 1'b1; fun_max = CND_FUN_MAX; end
      OP_IRMOV, OP_RMMOV, OP_MRMOV, OP_IADD: begin
        need_regids_o = 1'b1;
        need_valc_o   = 1'b1;
      end
      OP_ALU:  begin need_regids_o = 1'b1; fun_max = ALU_FUN_MAX; end
      OP_JUMP: begin need_valc_o = 1'b1; fun_max = CND_FUN_MAX; end
      OP_CALL: need_valc_o = 1'b1;
      OP_PUSH, OP_POP: need_regids_o = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign valid_o   = known && (ifun_i <= fun_max);
  assign is_halt_o = valid_o && (icode_i == OP_HALT);
endmodule

// File: rtl/fd_fields.sv
module fd_fields
  import fd_pkg::*;
#(
  parameter int WIN_BYTES = 10,
  parameter int WORD_W    = 64
) (
  input  logic [WIN_BYTES*8-1:0] window_i,
  input  logic                   need_regids_i,
  input  logic                   need_valc_i,
  output logic [3:0]             icode_o,
  output logic [3:0]             ifun_o,
  output logic [3:0]             ra_o,
  output logic [3:0]             rb_o,
  output logic [WORD_W-1:0]      valc_o
);
  localparam int CONST_BYTES = WORD_W / 8;

  logic [WORD_W-1:0] const_after_reg;
  logic [WORD_W-1:0] const_after_op;

  assign icode_o = window_i[7:4];
  assign ifun_o  = window_i[3:0];
  assign ra_o    = need_regids_i ? window_i[15:12] : REG_NONE;
  assign rb_o    = need_regids_i ? window_i[11:8]  : REG_NONE;

  // little-endian assembly at both possible offsets
  for (genvar b = 0; b < CONST_BYTES; b++) begin : g_cbyte
    assign const_after_reg[b*8 +: 8] = window_i[(b+2)*8 +: 8];
    assign const_after_op[b*8 +: 8]  = window_i[(b+1)*8 +: 8];
  end

  always_comb begin
    if (!need_valc_i)        valc_o = '0;
    else if (need_regids_i)  valc_o = const_after_reg;
    else                     valc_o = const_after_op;
  end
endmodule

// File: rtl/fd_pc_ctl.sv
module fd_pc_ctl
  import fd_pkg::*;
#(
  parameter int              PC_W     = 64,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] valp_i,
  input  logic            valid_i,
  input  logic            is_halt_i,
  output logic [PC_W-1:0] pc_o,
  output stat_e           stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= RESET_PC;
      stat_o <= ST_RUN;
    end else if (stat_o == ST_RUN) begin
      if (!valid_i)       stat_o <= ST_INV;
      else if (is_halt_i) stat_o <= ST_HALT;
      else                pc_o   <= valp_i;
    end
  end

  a_r10_inv_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o == ST_INV |=> stat_o == ST_INV && $stable(pc_o));
  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o == ST_HALT |=> stat_o == ST_HALT && $stable(pc_o));
endmodule

// File: rtl/insn_fetch_decode.sv
module insn_fetch_decode
  import fd_pkg::*;
#(
  parameter int              PC_W      = 64,
  parameter int              WORD_W    = 64,
  parameter int              WIN_BYTES = 10,
  parameter logic [PC_W-1:0] RESET_PC  = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [WIN_BYTES*8-1:0] window_i,
  output logic [PC_W-1:0]        pc_o,
  output logic [3:0]             icode_o,
  output logic [3:0]             ifun_o,
  output logic [3:0]             ra_o,
  output logic [3:0]             rb_o,
  output logic [WORD_W-1:0]      valc_o,
  output logic [PC_W-1:0]        valp_o,
  output logic                   need_regids_o,
  output logic                   need_valc_o,
  output logic                   instr_valid_o,
  output logic [1:0]             stat_o
);
  localparam int              CONST_BYTES = WORD_W / 8;
  localparam logic [PC_W-1:0] CONST_LEN   = PC_W'(CONST_BYTES);
  localparam logic [PC_W-1:0] ONE         = PC_W'(1);

  logic  is_halt;
  stat_e stat;

  fd_classify u_cls (
    .icode_i      (icode_o),
    .ifun_i       (ifun_o),
    .valid_o      (instr_valid_o),
    .need_regids_o(need_regids_o),
    .need_valc_o  (need_valc_o),
    .is_halt_o    (is_halt)
  );

  fd_fields #(.WIN_BYTES(WIN_BYTES), .WORD_W(WORD_W)) u_fld (
    .window_i     (window_i),
    .need_regids_i(need_regids_o),
    .need_valc_i  (need_valc_o),
    .icode_o      (icode_o),
    .ifun_o       (ifun_o),
    .ra_o         (ra_o),
    .rb_o         (rb_o),
    .valc_o       (valc_o)
  );

  assign valp_o = pc_o + ONE
                + (need_regids_o ? ONE : '0)
                + (need_valc_o ? CONST_LEN : '0);

  fd_pc_ctl #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valp_i   (valp_o),
    .valid_i  (instr_valid_o),
    .is_halt_i(is_halt),
    .pc_o     (pc_o),
    .stat_o   (stat)
  );

  assign stat_o = stat;

  a_r9_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat == ST_RUN && instr_valid_o && !is_halt |=> pc_o == $past(valp_o));
  a_r10_invalid_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat == ST_RUN && !instr_valid_o |=> stat == ST_INV && $stable(pc_o));
  a_r4_iadd_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && icode_o == OP_IADD |-> valp_o == pc_o + ONE + ONE + CONST_LEN);
  a_r5_alu_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && icode_o == OP_ALU |-> valp_o == pc_o + ONE + ONE && valc_o == '0);
endmodule

// File: tb/sim_insn_fetch_decode.sv
module sim_insn_fetch_decode;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [79:0] window;
  logic [63:0] pc, valc, valp;
  logic [3:0]  icode, ifun, ra, rb;
  logic        need_regids, need_valc, instr_valid;
  logic [1:0]  stat;
  logic [7:0]  mem [64];
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 10; k++) begin
      logic [5:0] a;
      a = pc[5:0] + 6'(k);
      window[k*8 +: 8] = mem[a];
    end
  end

  insn_fetch_decode u0 (
    .clk_i(clk), .rst_ni(rst_ni), .window_i(window), .pc_o(pc),
    .icode_o(icode), .ifun_o(ifun), .ra_o(ra), .rb_o(rb), .valc_o(valc),
    .valp_o(valp), .need_regids_o(need_regids), .need_valc_o(need_valc),
    .instr_valid_o(instr_valid), .stat_o(stat)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_word(int addr, logic [63:0] w);
    for (int b = 0; b < 8; b++) mem[(addr + b) % 64] = w[b*8 +: 8];
  endtask

  task automatic restart();
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    #3;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    restart();
    chk("R8 pc", pc, 64'd0);
    chk("R8 stat", 64'(stat), 64'd0);
  endtask

  task automatic t_iadd();
    restart();
    mem[0] = 8'hC0; mem[1] = 8'hF3;
    put_word(2, 64'h0000ABCDABCDABCD);
    #1;
    chk("R1 icode", 64'(icode), 64'hC);
    chk("R1 ifun", 64'(ifun), 64'h0);
    chk("R2 ra", 64'(ra), 64'hF);
    chk("R2 rb", 64'(rb), 64'h3);
    chk("R3 valc", valc, 64'h0000ABCDABCDABCD);
    chk("R4 flags", {61'd0, need_regids, need_valc, instr_valid}, 64'b111);
    chk("R4 valp", valp, 64'd10);
    step();
    chk("R9 pc", pc, 64'd10);
    chk("R9 stat", 64'(stat), 64'd0);
  endtask

  task automatic t_iadd_badfun();
    restart();
    mem[0] = 8'hC1; mem[1] = 8'hF3;
    #1;
    chk("R7 iadd fun1", 64'(instr_valid), 64'd0);
    step();
    chk("R10 stat", 64'(stat), 64'd2);
    step();
    chk("R10 pc frozen", pc, 64'd0);
  endtask

  task automatic t_alu();
    restart();
    mem[0] = 8'h60; mem[1] = 8'h12;
    mem[2] = 8'h63; mem[3] = 8'h45;
    mem[4] = 8'hAA; mem[5] = 8'hBB;
    #1;
    chk("R5 flags", {61'd0, need_regids, need_valc, instr_valid}, 64'b101);
    chk("R5 valp", valp, 64'd2);
    chk("R3 no const", valc, 64'd0);
    chk("R2 ra", 64'(ra), 64'h1);
    chk("R2 rb", 64'(rb), 64'h2);
    step();
    chk("R9 pc", pc, 64'd2);
    chk("R7 alu fun3", 64'(instr_valid), 64'd1);
    chk("R1 ifun", 64'(ifun), 64'h3);
    step();
    chk("R9 pc", pc, 64'd4);
  endtask

  task automatic t_alu_badfun();
    restart();
    mem[0] = 8'h64; mem[1] = 8'h12;
    #1;
    chk("R7 alu fun4", 64'(instr_valid), 64'd0);
    step();
    chk("R10 stat", 64'(stat), 64'd2);
    chk("R10 pc", pc, 64'd0);
  endtask

  task automatic t_lengths();
    restart();
    mem[0] = 8'h10;
    mem[1] = 8'h26; mem[2] = 8'h12;
    mem[3] = 8'h30; mem[4] = 8'hF2; put_word(5, 64'h1122334455667788);
    mem[13] = 8'h76; put_word(14, 64'h0000000000000020);
    mem[22] = 8'h00;
    #1;
    chk("R6 nop valp", valp, 64'd1);
    step();
    chk("R7 rrmov fun6", 64'(instr_valid), 64'd1);
    chk("R6 rrmov valp", valp, 64'd3);
    step();
    chk("R6 irmov valp", valp, 64'd13);
    chk("R3 irmov valc", valc, 64'h1122334455667788);
    step();
    chk("R6 jump valp", valp, 64'd22);
    chk("R3 jump valc", valc, 64'h20);
    chk("R2 jump ra", 64'(ra), 64'hF);
    chk("R2 jump rb", 64'(rb), 64'hF);
    step();
    chk("R9 pc", pc, 64'd22);
    step();
    chk("R11 stat", 64'(stat), 64'd1);
    step();
    chk("R11 pc held", pc, 64'd22);
  endtask

  task automatic t_bad_code();
    restart();
    mem[0] = 8'hD0;
    #1;
    chk("R7 code D", 64'(instr_valid), 64'd0);
    step();
    chk("R10 stat", 64'(stat), 64'd2);
  endtask

  initial begin
    t_reset();
    t_iadd();
    t_iadd_badfun();
    t_alu();
    t_alu_badfun();
    t_lengths();
    t_bad_code();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule